// File: doc/BRIEF.md
# Iterative Multiply/Divide Unit with HI/LO Result Pair

This block performs 32-bit integer multiplication and division, signed or unsigned, one bit per clock. A single `start_i` pulse, taken while the unit is idle, captures the operation code and both operands. The unit then runs one setup cycle and one iteration per operand bit. When the last iteration ends it writes the result into a HI/LO register pair and raises `done_o` for one cycle.

Multiplication uses Booth pair recoding. The multiplier bit and the bit to its right choose, on each step, between subtracting the multiplicand, adding it, or doing nothing. An arithmetic right shift of the accumulator/multiplier pair follows every step. The unsigned form reuses the same datapath: the multiplicand is zero-extended, and the weight of the top multiplier bit is fixed up when the result is written.

Division uses a restoring shift-left-and-subtract loop on the operand magnitudes, followed by a sign fix-up. Neither operation reports overflow. A zero divisor is not trapped and gives a fixed result.

Top module: `md_unit`

## Requirements
- R1: While reset is held, and immediately after it, `busy_o` and `done_o` are 0 and `hi_o` and `lo_o` are 0.
- R2: A `start_i` sampled high while `busy_o` is low sets `busy_o` at the next clock edge. `busy_o` then stays high for 33 cycles. At the edge that clears it, `done_o` goes high for exactly one cycle.
- R3: A `start_i` sampled while `busy_o` is high is ignored and does not change the result of the operation in flight.
- R4: `op_i` = 2'b00 (signed multiply) leaves bits 63:32 of the two's complement product in `hi_o` and bits 31:0 in `lo_o`.
- R5: `op_i` = 2'b01 (unsigned multiply) leaves bits 63:32 of the unsigned product in `hi_o` and bits 31:0 in `lo_o`. No overflow indication exists.
- R6: `op_i` = 2'b10 (signed divide) leaves the quotient, truncated toward zero, in `lo_o`. It leaves the remainder in `hi_o`, carrying the dividend's sign, so that dividend = quotient × divisor + remainder. The most negative value divided by -1 gives 32'h8000_0000 with remainder 0.
- R7: `op_i` = 2'b11 (unsigned divide) leaves the unsigned quotient in `lo_o` and the remainder in `hi_o`.
- R8: A divide of either kind with a zero divisor completes in the normal time. It gives `lo_o` = 32'hFFFF_FFFF and `hi_o` equal to the dividend.
- R9: `hi_o` and `lo_o` change only in the cycle in which `done_o` is high, and they hold their values otherwise.
- R10: Operands and operation code are sampled only on the accepting `start_i`. Changing `a_i`, `b_i` or `op_i` while busy has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation when idle |
| op_i | input | 2 | bit 1: divide, bit 0: unsigned |
| a_i | input | 32 | Multiplier / dividend |
| b_i | input | 32 | Multiplicand / divisor |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| hi_o | output | 32 | Product high word / remainder |
| lo_o | output | 32 | Product low word / quotient |

## Verification
The bench drives runs of ones in the multiplier, both extreme signed values, all-ones unsigned operands, and every sign combination of divide. A Booth step with the wrong pair decode or a logical shift would corrupt exactly these products. A missing unsigned fix-up would show up on any multiplier with its top bit set. A wrong sign rule shows up in the remainder's sign or in the quotient's rounding direction. The bench divides by zero with negative dividends to catch a sign fix-up applied to the fixed zero-divisor result. It re-pulses start and changes the operands mid-run, which a design that re-accepts or samples late would turn into a wrong result or a shifted done pulse.

// File: rtl/md_pkg.sv
package md_pkg;
  typedef enum logic [1:0] {
    MD_MUL_S = 2'b00,
    MD_MUL_U = 2'b01,
    MD_DIV_S = 2'b10,
    MD_DIV_U = 2'b11
  } md_op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_SETUP = 2'b01,
    ST_ITER  = 2'b10
  } md_state_e;
endpackage

// File: rtl/md_booth_step.sv
module md_booth_step #(
  parameter int W = 32
) (
  input  logic [W+1:0] acc_i,
  input  logic [W-1:0] mq_i,
  input  logic         q1_i,
  input  logic [W:0]   mcand_i,
  output logic [W+1:0] acc_o,
  output logic [W-1:0] mq_o,
  output logic         q1_o
);
  logic [W+1:0] mext;
  logic [W+1:0] sum;

  assign mext = {mcand_i[W], mcand_i};

  always_comb begin
    unique case ({mq_i[0], q1_i})
      2'b10:   sum = acc_i - mext;
      2'b01:   sum = acc_i + mext;
      default: sum = acc_i;
    endcase
  end

  // arithmetic right shift of {acc, mq, q1}
  assign acc_o = {sum[W+1], sum[W+1:1]};
  assign mq_o  = {sum[0], mq_i[W-1:1]};
  assign q1_o  = mq_i[0];
endmodule

// File: rtl/md_div_step.sv
module md_div_step #(
  parameter int W = 32
) (
  input  logic [W-1:0] rem_i,
  input  logic [W-1:0] quo_i,
  input  logic [W-1:0] dvsr_i,
  output logic [W-1:0] rem_o,
  output logic [W-1:0] quo_o
);
  logic [W:0]   shifted;
  logic [W+1:0] trial;
  logic         qbit;

  assign shifted = {rem_i, quo_i[W-1]};
  assign trial   = {1'b0, shifted} - {2'b00, dvsr_i};
  assign qbit    = ~trial[W+1];

  // negative trial: keep (restore) the shifted partial remainder
  assign rem_o = qbit ? trial[W-1:0] : shifted[W-1:0];
  assign quo_o = {quo_i[W-2:0], qbit};
endmodule

// File: rtl/md_ctrl.sv
module md_ctrl #(
  parameter int W = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic accept_o,
  output logic load_o,
  output logic step_o,
  output logic last_o
);
  import md_pkg::*;

  localparam int CW = $clog2(W);

  md_state_e      state_q;
  logic [CW-1:0]  cnt_q;

  assign busy_o   = (state_q != ST_IDLE);
  assign accept_o = start_i && (state_q == ST_IDLE);
  assign load_o   = (state_q == ST_SETUP);
  assign step_o   = (state_q == ST_ITER);
  assign last_o   = step_o && (cnt_q == CW'(W - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE:  if (start_i) state_q <= ST_SETUP;
        ST_SETUP: begin
          state_q <= ST_ITER;
          cnt_q   <= '0;
        end
        ST_ITER: begin
          cnt_q <= cnt_q + 1'b1;
          if (last_o) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  a_r2_setup_to_iter: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> step_o && !last_o);
  a_r3_no_accept_when_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o && !last_o |=> busy_o && !load_o);
endmodule

// File: rtl/md_unit.sv
module md_unit #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [1:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] hi_o,
  output logic [W-1:0] lo_o
);
  import md_pkg::*;

  logic accept, load, step, last;

  logic [1:0]   op_q;
  logic [W-1:0] a_q, b_q;
  logic [W+1:0] acc_q;
  logic [W-1:0] mq_q;
  logic         q1_q;
  logic [W:0]   mcand_q;
  logic         corr_q, neg_q_q, neg_r_q;
  logic [W-1:0] hi_q, lo_q;
  logic         done_q;

  logic [W+1:0] b_acc;
  logic [W-1:0] b_mq;
  logic         b_q1;
  logic [W-1:0] d_rem, d_quo;

  logic         is_div, is_uns, a_neg, b_neg;
  logic [W-1:0] a_mag, b_mag;

  assign is_div = op_q[1];
  assign is_uns = op_q[0];
  assign a_neg  = !is_uns && a_q[W-1];
  assign b_neg  = !is_uns && b_q[W-1];
  assign a_mag  = a_neg ? -a_q : a_q;
  assign b_mag  = b_neg ? -b_q : b_q;

  md_ctrl #(.W(W)) i_ctrl (
    .clk_i, .rst_ni, .start_i,
    .busy_o, .accept_o(accept), .load_o(load), .step_o(step), .last_o(last)
  );

  md_booth_step #(.W(W)) i_booth (
    .acc_i(acc_q), .mq_i(mq_q), .q1_i(q1_q), .mcand_i(mcand_q),
    .acc_o(b_acc), .mq_o(b_mq), .q1_o(b_q1)
  );

  md_div_step #(.W(W)) i_div (
    .rem_i(acc_q[W-1:0]), .quo_i(mq_q), .dvsr_i(mcand_q[W-1:0]),
    .rem_o(d_rem), .quo_o(d_quo)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q    <= '0;
      a_q     <= '0;
      b_q     <= '0;
      acc_q   <= '0;
      mq_q    <= '0;
      q1_q    <= 1'b0;
      mcand_q <= '0;
      corr_q  <= 1'b0;
      neg_q_q <= 1'b0;
      neg_r_q <= 1'b0;
      hi_q    <= '0;
      lo_q    <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= last;
      if (accept) begin
        op_q <= op_i;
        a_q  <= a_i;
        b_q  <= b_i;
      end
      if (load) begin
        acc_q <= '0;
        q1_q  <= 1'b0;
        if (is_div) begin
          mq_q    <= a_mag;
          mcand_q <= {1'b0, b_mag};
          neg_q_q <= !is_uns && (a_q[W-1] ^ b_q[W-1]) && (b_q != '0);
          neg_r_q <= a_neg;
          corr_q  <= 1'b0;
        end else begin
          mq_q    <= a_q;
          mcand_q <= {!is_uns && b_q[W-1], b_q};
          // top multiplier bit carries weight +2^(W-1) when unsigned
          corr_q  <= is_uns && a_q[W-1];
          neg_q_q <= 1'b0;
          neg_r_q <= 1'b0;
        end
      end
      if (step) begin
        if (is_div) begin
          acc_q <= {2'b00, d_rem};
          mq_q  <= d_quo;
        end else begin
          acc_q <= b_acc;
          mq_q  <= b_mq;
          q1_q  <= b_q1;
        end
      end
      if (last) begin
        if (is_div) begin
          hi_q <= neg_r_q ? -d_rem : d_rem;
          lo_q <= neg_q_q ? -d_quo : d_quo;
        end else begin
          hi_q <= b_acc[W-1:0] + (corr_q ? mcand_q[W-1:0] : '0);
          lo_q <= b_mq;
        end
      end
    end
  end

  assign done_o = done_q;
  assign hi_o   = hi_q;
  assign lo_o   = lo_q;

  a_r2_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r2_done_ends_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
  a_r2_start_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o |=> busy_o);
  a_r9_result_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(hi_o) && $stable(lo_o));
  a_r10_regs_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) |-> $stable(a_q) && $stable(b_q) && $stable(op_q));
endmodule

// File: tb/test_md_unit.sv
`timescale 1ns/1ps
module test_md_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  op = 2'b00;
  logic [31:0] a = '0, b = '0;
  logic        busy, done;
  logic [31:0] hi, lo;

  int n_chk = 0;
  int n_fail = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  md_unit #(.W(32)) i_md_unit (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op),
    .a_i(a), .b_i(b), .busy_o(busy), .done_o(done), .hi_o(hi), .lo_o(lo)
  );

  // behavioural reference
  logic        m_busy, m_done;
  logic [31:0] m_hi, m_lo, p_hi, p_lo;
  int          m_cnt;

  function automatic logic [63:0] ref_result(input logic [1:0] o,
                                             input logic [31:0] x, input logic [31:0] y);
    longint sx, sy, q, r;
    logic [63:0] u;
    sx = longint'($signed(x));
    sy = longint'($signed(y));
    case (o)
      2'b00: u = 64'(sx * sy);
      2'b01: u = {32'd0, x} * {32'd0, y};
      2'b10: begin
        if (y == 0) u = {x, 32'hFFFF_FFFF};
        else begin
          q = sx / sy;
          r = sx % sy;
          u = {r[31:0], q[31:0]};
        end
      end
      default: begin
        if (y == 0) u = {x, 32'hFFFF_FFFF};
        else u = {x % y, x / y};
      end
    endcase
    return u;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy <= 0; m_done <= 0; m_hi <= 0; m_lo <= 0; m_cnt <= 0;
      p_hi <= 0; p_lo <= 0;
    end else begin
      m_done <= 0;
      if (!m_busy) begin
        if (start) begin
          m_busy <= 1;
          m_cnt  <= 0;
          {p_hi, p_lo} <= ref_result(op, a, b);
        end
      end else if (m_cnt == 32) begin
        m_busy <= 0;
        m_done <= 1;
        m_hi   <= p_hi;
        m_lo   <= p_lo;
      end else m_cnt <= m_cnt + 1;
    end
  end

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // compare every cycle away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      check("R2", "busy", 32'(busy), 32'(m_busy));
      check("R2", "done", 32'(done), 32'(m_done));
      check(m_done ? cur_req : "R9", "hi", hi, m_hi);
      check(m_done ? cur_req : "R9", "lo", lo, m_lo);
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // perturb: 1 = re-pulse start mid-run (R3), 2 = change operands mid-run (R10)
  task automatic run(input logic [1:0] o, input logic [31:0] x, input logic [31:0] y,
                     input string req, input int perturb);
    while (busy) @(negedge clk);
    cur_req = req;
    #1;
    op = o; a = x; b = y; start = 1;
    @(negedge clk); #1;
    start = 0;
    repeat (5) @(negedge clk);
    #1;
    if (perturb != 0) begin
      op = ~o; a = ~x; b = y ^ 32'h0000_0005;
      if (perturb == 1) begin
        start = 1;
        @(negedge clk); #1;
        start = 0;
      end
    end
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "busy in reset", 32'(busy), 0);
    check("R1", "hi in reset", hi, 0);
    #1 rst_n = 1;
    @(negedge clk);
    check("R1", "done after reset", 32'(done), 0);
    check("R1", "lo after reset", lo, 0);

    run(2'b00, 32'd7, 32'd2, "R4", 0);
    run(2'b00, 32'd2, 32'hFFFF_FFFD, "R4", 0);
    run(2'b00, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R4", 0);
    run(2'b00, 32'h8000_0000, 32'h8000_0000, "R4", 0);
    run(2'b00, 32'h7FFF_FFFF, 32'h8000_0000, "R4", 0);
    run(2'b00, 32'h0F0F_7FF0, 32'hDEAD_BEEF, "R4", 0);
    run(2'b01, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R5", 0);
    run(2'b01, 32'h8000_0000, 32'd2, "R5", 0);
    run(2'b01, 32'd3, 32'hF000_0001, "R5", 0);
    run(2'b10, 32'd7, 32'd2, "R6", 0);
    run(2'b10, 32'hFFFF_FFF9, 32'd2, "R6", 0);
    run(2'b10, 32'd7, 32'hFFFF_FFFE, "R6", 0);
    run(2'b10, 32'hFFFF_FFF9, 32'hFFFF_FFFE, "R6", 0);
    run(2'b10, 32'h8000_0000, 32'hFFFF_FFFF, "R6", 0);
    run(2'b11, 32'hFFFF_FFFF, 32'd3, "R7", 0);
    run(2'b11, 32'd5, 32'hFFFF_0000, "R7", 0);
    run(2'b11, 32'h8000_0001, 32'h8000_0000, "R7", 0);
    run(2'b10, 32'hFFFF_FF00, 32'd0, "R8", 0);
    run(2'b10, 32'h0000_1234, 32'd0, "R8", 0);
    run(2'b11, 32'h8765_4321, 32'd0, "R8", 0);
    run(2'b00, 32'h1234_5678, 32'h9ABC_DEF0, "R3", 1);
    run(2'b11, 32'h0001_0000, 32'd7, "R3", 1);
    run(2'b10, 32'hFFFF_0000, 32'd9, "R10", 2);
    run(2'b01, 32'hCAFE_0001, 32'h0000_FFFF, "R10", 2);
    repeat (10) @(negedge clk);
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R2 watchdog actual=hung expected=finished");
    summary();
  end
endmodule